// File: doc/BRIEF.md
# SD host command-issue controller

This block is the register-side front end that launches commands in an SD/MMC host. Software writes a command word into a small register file. When the start bit of that word is set, the block holds the word, raises a start flag and offers the command to a card-side sender through a level start and a one-cycle done pulse. The block drops the start flag by itself once the sender reports that the command has gone out. Completion, refused writes, response errors and boot-acknowledge timeouts are posted as sticky interrupt status bits. Software clears these bits by writing 1 to them, and each bit can be enabled onto a single interrupt line.

The command word also carries control fields. A two-bit boot mode selects a normal command, a mandatory boot or an alternate boot. Other bits request a boot acknowledge, mark a voltage-switch command, route traffic through a hold register, and abort a boot in progress. For a mandatory boot with acknowledge requested, the block watches the card's data line on card-clock ticks for a low-high-low pattern. A programmable limit bounds that wait. A byte-count register sits next to the command register for the transfer logic to use.

Register addresses: 0 command, 1 byte count, 2 interrupt status, 3 interrupt enable, 4 acknowledge limit. All reads are combinational on `reg_raddr`.

Top module: `sdh_cmd_issue`

## Requirements
- R1: The byte-count register at address 1 resets to 0x200 and reads back whatever 32-bit value was last written to it.
- R2: When no command is pending, a write to address 0 stores the word. If bit 31 is set, the write also makes bit 31 read back as 1, raises `snd_start` and presents bits 23:0 on `snd_payload`. If bit 31 is clear, only the fields are stored and `snd_start` stays low.
- R3: On the clock edge where `snd_done` is sampled high for a command that needs no boot acknowledge, the pending bit (command bit 31) clears and `snd_start` falls.
- R4: A finished command sets status bit 0 when `snd_resp_err` was low with `snd_done`. If `snd_resp_err` was high, it sets status bit 2 and leaves bit 0 alone. The pending bit clears in both cases.
- R5: A write to address 0 while bit 31 reads 1 is refused and sets status bit 1. The stored command word does not change, and no new command is sent.
- R6: Writing 1 to a bit at address 2 clears that status bit, and writing 0 leaves it unchanged. If hardware sets a bit in the same cycle that software clears it, the bit ends up set.
- R7: `irq` is high exactly when some status bit and the matching bit at address 3 are both 1.
- R8: Command bits 25:24 drive `boot_mode`: 01 is mandatory boot, 10 is alternate boot, and 00 or 11 give 00 (normal). Bit 28 drives `volt_switch` and bit 29 drives `hold_path`. `boot_active` is high while a mandatory or alternate boot command is pending.
- R9: A mandatory boot with bit 26 set completes only after the sender is done and `card_dat0` has been sampled on `card_tick` as 0, then 1, then 0 (repeats allowed in between). An alternate boot with bit 26 set completes on sender done alone.
- R10: When the limit at address 4 is non-zero and that many `card_tick` cycles pass without the acknowledge pattern, status bit 3 is set, the pending bit clears and bit 0 is not set. A limit of 0 waits without bound.
- R11: A write to address 0 with bit 27 set while `boot_active` is high ends the boot. The pending bit clears, and no status bit is set. For a pending non-boot command the same write is refused as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| snd_start | output | 1 | Command offered to the sender |
| snd_payload | output | 24 | Command payload for the sender |
| snd_done | input | 1 | Sender finished, one-cycle pulse |
| snd_resp_err | input | 1 | Response error, valid with `snd_done` |
| card_tick | input | 1 | Card-clock sample enable |
| card_dat0 | input | 1 | Card data line 0 |
| boot_mode | output | 2 | Effective boot mode |
| volt_switch | output | 1 | Voltage-switch command flag |
| hold_path | output | 1 | Route through the hold register |
| boot_active | output | 1 | Boot command pending |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: the hardware setting of a status bit when a command finishes, and a software write that clears that same bit. The bench sets the done bit once, starts a second command, and then drives `snd_done` in the very cycle that it writes 1 to status bit 0. A read afterwards must still show bit 0 set, with the pending bit cleared. The bench also checks that a write arriving while a command is pending does not disturb the command the scoreboard expects the sender to receive.

// File: rtl/sdh_cmd_pkg.sv
`timescale 1ns/1ps
package sdh_cmd_pkg;
  localparam int DW     = 32;
  localparam int REG_AW = 3;
  localparam int PAY_W  = 24;
  localparam int NIRQ   = 4;

  localparam logic [REG_AW-1:0] A_CMD    = 3'd0;
  localparam logic [REG_AW-1:0] A_BYTES  = 3'd1;
  localparam logic [REG_AW-1:0] A_ISTS   = 3'd2;
  localparam logic [REG_AW-1:0] A_IEN    = 3'd3;
  localparam logic [REG_AW-1:0] A_ACKLIM = 3'd4;

  // command word bit positions (software encoding)
  localparam int B_START   = 31;
  localparam int B_HOLD    = 29;
  localparam int B_VSW     = 28;
  localparam int B_ABORT   = 27;
  localparam int B_ACKREQ  = 26;
  localparam int B_MODE_HI = 25;
  localparam int B_MODE_LO = 24;

  // interrupt status bit positions
  localparam int I_DONE = 0;
  localparam int I_BUSY = 1;
  localparam int I_RERR = 2;
  localparam int I_ATMO = 3;

  typedef enum logic [1:0] {
    BM_NORMAL = 2'b00,
    BM_MAND   = 2'b01,
    BM_ALT    = 2'b10
  } boot_e;

  // reserved code maps to a normal command
  function automatic boot_e eff_boot(input logic [1:0] f);
    case (f)
      2'b01:   return BM_MAND;
      2'b10:   return BM_ALT;
      default: return BM_NORMAL;
    endcase
  endfunction

  function automatic logic needs_ack(input logic [1:0] f, input logic req);
    return req && (eff_boot(f) == BM_MAND);
  endfunction

  function automatic logic limit_hit(input logic [DW-1:0] cnt_next,
                                     input logic [DW-1:0] lim);
    return (lim != '0) && (cnt_next == lim);
  endfunction
endpackage

// File: rtl/sdh_boot_ack.sv
`timescale 1ns/1ps
module sdh_boot_ack
  import sdh_cmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             clear,
  input  logic             tick,
  input  logic             dat,
  input  logic [CNT_W-1:0] limit,
  output logic             armed,
  output logic             ack_ok,
  output logic             ack_tmo
);
  typedef enum logic [1:0] {AK_IDLE, AK_LOW1, AK_HIGH, AK_LOW2} ak_e;
  ak_e              st;
  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    armed   = (st != AK_IDLE);
    cnt_nx  = cnt + 1'b1;
    ack_ok  = tick && (st == AK_LOW2) && !dat;
    ack_tmo = tick && armed && !ack_ok &&
              limit_hit(DW'(cnt_nx), DW'(limit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= AK_IDLE;
      cnt <= '0;
    end else if (clear || ack_ok || ack_tmo) begin
      st  <= AK_IDLE;
      cnt <= '0;
    end else if (arm) begin
      st  <= AK_LOW1;
      cnt <= '0;
    end else if (tick && armed) begin
      cnt <= cnt_nx;
      case (st)
        AK_LOW1: if (!dat) st <= AK_HIGH;
        AK_HIGH: if (dat)  st <= AK_LOW2;
        default: st <= st;
      endcase
    end
  end

  // R9
  ack_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm && !clear |=> armed);

  // R10
  ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ok || ack_tmo) |=> !armed);
endmodule

// File: rtl/sdh_irq_regs.sv
`timescale 1ns/1ps
module sdh_irq_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_we,
  input  logic [N-1:0] clr_vec,
  input  logic         en_we,
  input  logic [N-1:0] en_wd,
  output logic [N-1:0] sts,
  output logic [N-1:0] en,
  output logic         irq
);
  logic [N-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_we ? clr_vec : '0;
    irq      = |(sts & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
    end else begin
      sts <= (sts & ~clr_mask) | set_vec;
      if (en_we) en <= en_wd;
    end
  end

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((sts & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/sdh_cmd_ctrl.sv
`timescale 1ns/1ps
module sdh_cmd_ctrl
  import sdh_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [DW-1:0] cmd_wd,
  input  logic          snd_done,
  input  logic          snd_resp_err,
  input  logic          ack_ok,
  input  logic          ack_tmo,
  output logic          pend,
  output logic [DW-2:0] cmd_q,
  output logic          snd_start,
  output logic          arm_ack,
  output logic          boot_active,
  output logic          done_ev,
  output logic          busy_ev,
  output logic          rerr_ev,
  output logic          tmo_ev,
  output logic          abort_ev
);
  logic          sent, ack_seen, err_q;
  logic          need, finish, err_now, launch, idle_wr;
  logic [DW-2:0] wd_keep;

  always_comb begin
    need        = needs_ack(cmd_q[B_MODE_HI:B_MODE_LO], cmd_q[B_ACKREQ]);
    boot_active = pend && (eff_boot(cmd_q[B_MODE_HI:B_MODE_LO]) != BM_NORMAL);
    idle_wr     = cmd_we && !pend;
    launch      = idle_wr && cmd_wd[B_START];
    abort_ev    = cmd_we && pend && cmd_wd[B_ABORT] && boot_active;
    busy_ev     = cmd_we && pend && !abort_ev;
    err_now     = snd_done ? snd_resp_err : err_q;
    finish      = pend && !abort_ev && (sent || snd_done) &&
                  (!need || ack_seen || ack_ok);
    tmo_ev      = pend && !abort_ev && need && ack_tmo;
    done_ev     = finish && !err_now;
    rerr_ev     = finish && err_now;
    snd_start   = pend && !sent;
    arm_ack     = launch && needs_ack(cmd_wd[B_MODE_HI:B_MODE_LO], cmd_wd[B_ACKREQ]);
    wd_keep          = cmd_wd[DW-2:0];
    wd_keep[B_ABORT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      cmd_q    <= '0;
      sent     <= 1'b0;
      ack_seen <= 1'b0;
      err_q    <= 1'b0;
    end else if (idle_wr) begin
      cmd_q    <= wd_keep;
      pend     <= cmd_wd[B_START];
      sent     <= 1'b0;
      ack_seen <= 1'b0;
      err_q    <= 1'b0;
    end else if (pend) begin
      if (finish || tmo_ev || abort_ev) pend <= 1'b0;
      if (snd_done) begin
        sent  <= 1'b1;
        err_q <= snd_resp_err;
      end
      if (ack_ok) ack_seen <= 1'b1;
    end
  end

  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(finish || tmo_ev || abort_ev));

  // R5
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_ev |=> (cmd_q == $past(cmd_q)));

  // R3
  handoff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_done && pend && !cmd_we) |=> !snd_start);

  // R4
  single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ev, rerr_ev, tmo_ev, abort_ev}));
endmodule

// File: rtl/sdh_cmd_issue.sv
`timescale 1ns/1ps
module sdh_cmd_issue
  import sdh_cmd_pkg::*;
#(
  parameter logic [31:0] BYTES_RST   = 32'h0000_0200,
  parameter int          CNT_W       = 16,
  parameter int          ACK_LIM_RST = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [DW-1:0]     reg_rdata,
  output logic              snd_start,
  output logic [PAY_W-1:0]  snd_payload,
  input  logic              snd_done,
  input  logic              snd_resp_err,
  input  logic              card_tick,
  input  logic              card_dat0,
  output logic [1:0]        boot_mode,
  output logic              volt_switch,
  output logic              hold_path,
  output logic              boot_active,
  output logic              irq
);
  logic [DW-1:0]    byte_cnt;
  logic [CNT_W-1:0] ack_lim;
  logic             pend, arm_ack, ack_ok, ack_tmo, ack_armed;
  logic             done_ev, busy_ev, rerr_ev, tmo_ev, abort_ev;
  logic [DW-2:0]    cmd_q;
  logic [NIRQ-1:0]  sts, ien, set_vec;
  logic             we_cmd, we_bytes, we_ists, we_ien, we_lim;

  always_comb begin
    we_cmd   = reg_wr && (reg_addr == A_CMD);
    we_bytes = reg_wr && (reg_addr == A_BYTES);
    we_ists  = reg_wr && (reg_addr == A_ISTS);
    we_ien   = reg_wr && (reg_addr == A_IEN);
    we_lim   = reg_wr && (reg_addr == A_ACKLIM);
    set_vec          = '0;
    set_vec[I_DONE]  = done_ev;
    set_vec[I_BUSY]  = busy_ev;
    set_vec[I_RERR]  = rerr_ev;
    set_vec[I_ATMO]  = tmo_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_cnt <= BYTES_RST;
      ack_lim  <= CNT_W'(ACK_LIM_RST);
    end else begin
      if (we_bytes) byte_cnt <= reg_wdata;
      if (we_lim)   ack_lim  <= reg_wdata[CNT_W-1:0];
    end
  end

  sdh_cmd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (we_cmd),
    .cmd_wd       (reg_wdata),
    .snd_done     (snd_done),
    .snd_resp_err (snd_resp_err),
    .ack_ok       (ack_ok),
    .ack_tmo      (ack_tmo),
    .pend         (pend),
    .cmd_q        (cmd_q),
    .snd_start    (snd_start),
    .arm_ack      (arm_ack),
    .boot_active  (boot_active),
    .done_ev      (done_ev),
    .busy_ev      (busy_ev),
    .rerr_ev      (rerr_ev),
    .tmo_ev       (tmo_ev),
    .abort_ev     (abort_ev)
  );

  sdh_boot_ack #(.CNT_W(CNT_W)) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm_ack),
    .clear   (abort_ev),
    .tick    (card_tick),
    .dat     (card_dat0),
    .limit   (ack_lim),
    .armed   (ack_armed),
    .ack_ok  (ack_ok),
    .ack_tmo (ack_tmo)
  );

  sdh_irq_regs #(.N(NIRQ)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_we  (we_ists),
    .clr_vec (reg_wdata[NIRQ-1:0]),
    .en_we   (we_ien),
    .en_wd   (reg_wdata[NIRQ-1:0]),
    .sts     (sts),
    .en      (ien),
    .irq     (irq)
  );

  always_comb begin
    snd_payload = cmd_q[PAY_W-1:0];
    boot_mode   = eff_boot(cmd_q[B_MODE_HI:B_MODE_LO]);
    volt_switch = cmd_q[B_VSW];
    hold_path   = cmd_q[B_HOLD];
    case (reg_raddr)
      A_CMD:    reg_rdata = {pend, cmd_q};
      A_BYTES:  reg_rdata = byte_cnt;
      A_ISTS:   reg_rdata = DW'(sts);
      A_IEN:    reg_rdata = DW'(ien);
      A_ACKLIM: reg_rdata = DW'(ack_lim);
      default:  reg_rdata = '0;
    endcase
  end

  // R10
  ack_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_armed |-> pend);

  // R2
  start_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snd_start |-> reg_rdata[B_START] || (reg_raddr != A_CMD));
endmodule

// File: tb/sim_sdh_cmd_issue.sv
`timescale 1ns/1ps
module sim_sdh_cmd_issue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        snd_start;
  logic [23:0] snd_payload;
  logic        snd_done = 1'b0, snd_resp_err = 1'b0;
  logic        card_tick = 1'b0, card_dat0 = 1'b1;
  logic [1:0]  boot_mode;
  logic        volt_switch, hold_path, boot_active, irq;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  logic        prev_start = 1'b0;

  always #10 clk = ~clk;

  sdh_cmd_issue u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .snd_start(snd_start), .snd_payload(snd_payload), .snd_done(snd_done),
    .snd_resp_err(snd_resp_err), .card_tick(card_tick), .card_dat0(card_dat0),
    .boot_mode(boot_mode), .volt_switch(volt_switch), .hold_path(hold_path),
    .boot_active(boot_active), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: each new offer to the sender must match the oldest expected payload
  always @(posedge clk) begin
    prev_start <= snd_start;
    if (rst_n && snd_start && !prev_start) begin
      if (exp_q.size() == 0) chk("R2 unexpected send", {8'h0, snd_payload}, 32'hFFFF_FFFF);
      else chk("R2 payload", {8'h0, snd_payload}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w);
    exp_q.push_back(w[23:0]);
    wr(3'd0, w);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_raddr = a; #1; v = reg_rdata;
  endtask

  task automatic pulse(input logic e);
    @(negedge clk); snd_done = 1'b1; snd_resp_err = e;
    @(negedge clk); snd_done = 1'b0; snd_resp_err = 1'b0;
  endtask

  task automatic tick(input logic d);
    @(negedge clk); card_tick = 1'b1; card_dat0 = d;
    @(negedge clk); card_tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd(3'd1, v); chk("R1 reset bytes", v, 32'h200);
    rd(3'd0, v); chk("R2 reset cmd", v, 32'h0);
    rd(3'd2, v); chk("R6 reset status", v, 32'h0);
    chk("R7 reset irq", {31'h0, irq}, 32'h0);
    wr(3'd1, 32'h0000_1000); rd(3'd1, v); chk("R1 bytes rw", v, 32'h1000);
    wr(3'd3, 32'hF);

    // plain command
    issue(32'h8000_0011);
    rd(3'd0, v); chk("R2 cmd pending", v, 32'h8000_0011);
    chk("R2 start high", {31'h0, snd_start}, 32'h1);
    pulse(1'b0);
    chk("R3 start low", {31'h0, snd_start}, 32'h0);
    rd(3'd0, v); chk("R3 self clear", v, 32'h0000_0011);
    rd(3'd2, v); chk("R4 done bit", v, 32'h1);
    chk("R7 irq on", {31'h0, irq}, 32'h1);
    wr(3'd2, 32'h0); rd(3'd2, v); chk("R6 write zero", v, 32'h1);
    wr(3'd2, 32'h1); rd(3'd2, v); chk("R6 w1c", v, 32'h0);
    chk("R7 irq off", {31'h0, irq}, 32'h0);

    // refused write, then response error
    issue(32'h8000_0022);
    wr(3'd0, 32'h8000_0033);
    rd(3'd2, v); chk("R5 busy bit", v, 32'h2);
    rd(3'd0, v); chk("R5 word kept", v, 32'h8000_0022);
    pulse(1'b1);
    rd(3'd2, v); chk("R4 resp err", v, 32'h6);
    rd(3'd0, v); chk("R4 cleared on err", {31'h0, v[31]}, 32'h0);
    wr(3'd3, 32'h8); chk("R7 masked", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'hF);
    wr(3'd2, 32'hF);

    // set and clear of the same status bit in one cycle
    issue(32'h8000_0044); pulse(1'b0);
    issue(32'h8000_0055);
    @(negedge clk); snd_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
    @(negedge clk); snd_done = 1'b0; reg_wr = 1'b0;
    rd(3'd2, v); chk("R6 set wins", v, 32'h1);
    rd(3'd0, v); chk("R3 cleared at collide", {31'h0, v[31]}, 32'h0);
    wr(3'd2, 32'hF);

    // control fields
    wr(3'd0, 32'h3300_0000);
    chk("R8 reserved mode", {30'h0, boot_mode}, 32'h0);
    chk("R8 vsw hold", {30'h0, volt_switch, hold_path}, 32'h3);
    chk("R2 no start", {31'h0, snd_start}, 32'h0);
    issue(32'h8100_0066);
    chk("R8 mandatory", {30'h0, boot_mode}, 32'h1);
    chk("R8 boot active", {31'h0, boot_active}, 32'h1);
    pulse(1'b0);
    rd(3'd2, v); chk("R9 no ack needed", v, 32'h1);
    wr(3'd2, 32'hF);

    // acknowledge pattern
    wr(3'd4, 32'd20);
    issue(32'h8500_0077);
    pulse(1'b0);
    rd(3'd0, v); chk("R9 waits ack", {31'h0, v[31]}, 32'h1);
    tick(1'b1); tick(1'b0); tick(1'b1);
    rd(3'd0, v); chk("R9 partial pattern", {31'h0, v[31]}, 32'h1);
    tick(1'b0);
    rd(3'd0, v); chk("R9 ack done", {31'h0, v[31]}, 32'h0);
    rd(3'd2, v); chk("R9 done bit", v, 32'h1);
    wr(3'd2, 32'hF);
    issue(32'h8600_0088);
    chk("R8 alternate", {30'h0, boot_mode}, 32'h2);
    pulse(1'b0);
    rd(3'd0, v); chk("R9 alt no check", {31'h0, v[31]}, 32'h0);
    wr(3'd2, 32'hF);

    // acknowledge timeout
    wr(3'd4, 32'd5);
    issue(32'h8500_0099);
    pulse(1'b0);
    for (int i = 0; i < 4; i++) tick(1'b1);
    rd(3'd0, v); chk("R10 before limit", {31'h0, v[31]}, 32'h1);
    tick(1'b1);
    rd(3'd0, v); chk("R10 abandoned", {31'h0, v[31]}, 32'h0);
    rd(3'd2, v); chk("R10 timeout bit", v, 32'h8);
    wr(3'd2, 32'hF);

    // unbounded wait, then abort
    wr(3'd4, 32'd0);
    issue(32'h8500_00AA);
    pulse(1'b0);
    for (int i = 0; i < 10; i++) tick(1'b1);
    rd(3'd0, v); chk("R10 zero limit", {31'h0, v[31]}, 32'h1);
    wr(3'd0, 32'h0800_0000);
    rd(3'd0, v); chk("R11 abort clears", {31'h0, v[31]}, 32'h0);
    rd(3'd2, v); chk("R11 no status", v, 32'h0);
    chk("R11 boot ended", {31'h0, boot_active}, 32'h0);
    issue(32'h8000_00BB);
    wr(3'd0, 32'h0800_0000);
    rd(3'd2, v); chk("R11 abort on normal refused", v, 32'h2);
    pulse(1'b0);
    rd(3'd2, v); chk("R4 done after refusal", v, 32'h3);

    repeat (3) @(negedge clk);
    chk("R2 all sends seen", exp_q.size(), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule